// File: doc/BRIEF.md
# Decoded Micro-Op Window Cache

This controller keeps already-decoded micro-ops so that code which runs again can skip the decoder. Code is split into aligned 32-byte windows. Each cached entry is keyed by the exact byte address at which execution entered its window. If the same window is entered at two different offsets, it occupies two separate entries. An entry holds at most eighteen micro-ops, which are returned as up to three lines of six.

The decoder fills an entry through a streaming port. It raises a start strobe with the entry address, then sends one micro-op per cycle, each with branch markers, and flags the final op. The fill is committed only if the window obeys three rules: it has no more than eighteen ops, it has no more than six branches, and any unconditional branch is the final op. A fill that breaks any rule leaves the cache untouched. Which window an instruction belongs to, including one that straddles a window edge, is decided by the decoder before filling.

A lookup takes one cycle and answers hit or miss. On a hit, the entry's lines follow on consecutive cycles. The response also gives the fall-through fetch address, which is the base of the next window, whenever the entry does not end in an unconditional branch. An instruction-cache eviction port names a 64-byte line and removes every entry of both windows inside it.

Top module: `uopc_ctrl`

## Requirements
- R1: After reset no entry is valid: every lookup misses, and rsp_valid and line_valid are low until a lookup is made.
- R2: A lookup hits only on the exact byte address given at fill start. Another offset in the same 32-byte window misses unless it was filled on its own, and each such entry returns its own ops.
- R3: rsp_valid rises exactly one cycle after an accepted lookup. On a hit, line k (k = 0, 1, 2) appears k cycles later with line_valid high. Line k carries ops 6k to 6k+5 in fill order, with op j of the line in line_ops bits [16j+15:16j] at the default width. line_count gives the number of ops in the line (1 to 6), and line_last marks the final line. A miss gives rsp_hit low and no line.
- R4: A fill of 18 ops is stored. A fill of 19 or more ops is discarded.
- R5: A fill with exactly 6 branch ops is stored. A fill with 7 is discarded. An op counts as a branch when either fill_op_branch or fill_op_uncond is high.
- R6: An unconditional branch is accepted only as the final op (the one with fill_op_end). A fill with any op after an unconditional branch is discarded.
- R7: On a hit to an entry whose last op is not an unconditional branch, next_valid is high and next_addr equals the lookup address with bits [4:0] cleared, plus 32. On a hit to an entry that ends in an unconditional branch, next_valid is low.
- R8: inv_valid removes every entry whose address bits [ADDR_W-1:6] equal those of inv_addr. This covers both 32-byte windows of that 64-byte line. Entries in other lines stay valid.
- R9: If inv_valid names the 64-byte line of a fill in progress, in any cycle from the one after fill_start up to and including the end op, the fill is discarded. An invalidation of another line leaves the fill intact.
- R10: A committed fill goes, in order of preference, to the entry holding the same address, then to the lowest-numbered free entry, then to a round-robin victim. The victim pointer starts at entry 0 after reset and moves on only when a victim is taken.
- R11: A lookup request that arrives while a hit is still streaming and its final line is not yet on the outputs is ignored. The stream continues unchanged and no response is given for that request.
- R12: A lookup made in the same cycle as an invalidation of its 64-byte line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_start | input | 1 | Begins a fill at fill_addr |
| fill_addr | input | ADDR_W | Entry byte address of the window being filled |
| fill_op_valid | input | 1 | A micro-op is presented on the fill port |
| fill_op | input | UOP_W | Micro-op payload |
| fill_op_branch | input | 1 | Op is a conditional branch |
| fill_op_uncond | input | 1 | Op is an unconditional branch |
| fill_op_end | input | 1 | Op is the last one of the window |
| inv_valid | input | 1 | Evict a 64-byte code line |
| inv_addr | input | ADDR_W | Any byte address inside the evicted line |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Fetch byte address to look up |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Lookup hit |
| next_valid | output | 1 | Fall-through address is valid |
| next_addr | output | ADDR_W | Base of the following window |
| line_valid | output | 1 | A line of ops is present |
| line_ops | output | 6*UOP_W | Six op slots, slot 0 in the low bits |
| line_count | output | 3 | Number of ops in this line |
| line_last | output | 1 | Final line of the entry |

## Verification
A wrong tag or a stale valid bit shows up as a hit or a miss on the very response cycle after a lookup. Wrong packing in the stored data shows up as ops that are out of order or shifted within the two following line cycles. A fill-rule counter that drifts shows up only at the rule boundaries, so those exact counts (18 against 19 ops, 6 against 7 branches) are compared one lookup after the fill. A faulty replacement pointer hides until the cache is full, and it becomes visible two fills later as the wrong survivor set.

// File: rtl/uopc_pkg.sv
package uopc_pkg;
    localparam int UC_OPS_PER_LINE  = 6;
    localparam int UC_LINES_PER_ENT = 3;
    localparam int UC_OPS_PER_ENT   = UC_OPS_PER_LINE * UC_LINES_PER_ENT;
    localparam int UC_MAX_BRANCHES  = 6;
    localparam int UC_WIN_OFS_BITS  = 5;
    localparam int UC_ICL_OFS_BITS  = 6;
endpackage

// File: rtl/uopc_fill_gate.sv
module uopc_fill_gate #(
    parameter int AW    = 32,
    parameter int UW    = 16,
    parameter int OPS   = 18,
    parameter int MAXBR = 6,
    parameter int ICLB  = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [AW-1:0]                 start_addr,
    input  logic                          op_valid,
    input  logic [UW-1:0]                 op,
    input  logic                          op_br,
    input  logic                          op_unc,
    input  logic                          op_end,
    input  logic                          inv_valid,
    input  logic [AW-1:0]                 inv_addr,
    output logic                          commit,
    output logic [AW-1:0]                 commit_addr,
    output logic [$clog2(OPS+1)-1:0]      commit_cnt,
    output logic                          commit_unc,
    output logic [OPS*UW-1:0]             commit_ops
);
    localparam int CW = $clog2(OPS + 1);
    localparam int BW = $clog2(MAXBR + 1);

    typedef struct packed {
        logic              active;
        logic              bad;
        logic              unc_seen;
        logic [CW-1:0]     cnt;
        logic [BW-1:0]     brc;
        logic [AW-1:0]     addr;
        logic [OPS*UW-1:0] ops;
    } gate_st_t;

    gate_st_t st_q, st_d;
    logic     kill;
    logic     commit_d;
    logic     unc_d;

    always_comb begin
        st_d     = st_q;
        commit_d = 1'b0;
        unc_d    = 1'b0;
        kill     = inv_valid && st_q.active &&
                   (inv_addr[AW-1:ICLB] == st_q.addr[AW-1:ICLB]);
        if (start) begin
            st_d.active   = 1'b1;
            st_d.bad      = 1'b0;
            st_d.unc_seen = 1'b0;
            st_d.cnt      = '0;
            st_d.brc      = '0;
            st_d.addr     = start_addr;
            st_d.ops      = '0;
        end else if (st_q.active && op_valid) begin
            if (st_q.cnt == CW'(OPS)) begin
                st_d.bad = 1'b1;
            end else begin
                st_d.ops[int'(st_q.cnt)*UW +: UW] = op;
                st_d.cnt = st_q.cnt + CW'(1);
            end
            if (op_br || op_unc) begin
                if (st_q.brc == BW'(MAXBR)) st_d.bad = 1'b1;
                else                         st_d.brc = st_q.brc + BW'(1);
            end
            if (st_q.unc_seen) st_d.bad = 1'b1;
            if (op_unc) st_d.unc_seen = 1'b1;
            if (op_end) begin
                st_d.active = 1'b0;
                commit_d    = !st_d.bad && !kill;
                unc_d       = op_unc;
            end
        end
        if (kill && !start) st_d.active = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit      = commit_d;
    assign commit_unc  = unc_d;
    assign commit_addr = st_q.addr;
    assign commit_cnt  = st_d.cnt;
    assign commit_ops  = st_d.ops;
endmodule

// File: rtl/uopc_store.sv
module uopc_store #(
    parameter int AW   = 32,
    parameter int UW   = 16,
    parameter int OPS  = 18,
    parameter int N    = 85,
    parameter int ICLB = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic [AW-1:0]            c_addr,
    input  logic [$clog2(OPS+1)-1:0] c_cnt,
    input  logic                     c_unc,
    input  logic [OPS*UW-1:0]        c_ops,
    input  logic                     inv_valid,
    input  logic [AW-1:0]            inv_addr,
    input  logic [AW-1:0]            lk_addr,
    output logic                     lk_hit,
    output logic [$clog2(OPS+1)-1:0] lk_cnt,
    output logic                     lk_unc,
    output logic [OPS*UW-1:0]        lk_ops
);
    localparam int CW = $clog2(OPS + 1);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]              vld;
        logic [N-1:0][AW-1:0]      key;
        logic [N-1:0][CW-1:0]      cnt;
        logic [N-1:0]              unc;
        logic [N-1:0][OPS*UW-1:0]  data;
        logic [IW-1:0]             rr;
    } store_st_t;

    store_st_t     st_q, st_d;
    logic          same_f, free_f, look_f;
    logic [IW-1:0] same_i, free_i, look_i, tgt;
    logic          lk_killed;

    always_comb begin
        same_f = 1'b0; same_i = '0;
        free_f = 1'b0; free_i = '0;
        look_f = 1'b0; look_i = '0;
        for (int i = 0; i < N; i++) begin
            if (!same_f && st_q.vld[i] && st_q.key[i] == c_addr) begin
                same_f = 1'b1;
                same_i = IW'(i);
            end
            if (!free_f && !st_q.vld[i]) begin
                free_f = 1'b1;
                free_i = IW'(i);
            end
            if (!look_f && st_q.vld[i] && st_q.key[i] == lk_addr) begin
                look_f = 1'b1;
                look_i = IW'(i);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        tgt  = same_f ? same_i : (free_f ? free_i : st_q.rr);
        if (inv_valid) begin
            for (int i = 0; i < N; i++) begin
                if (st_q.key[i][AW-1:ICLB] == inv_addr[AW-1:ICLB]) st_d.vld[i] = 1'b0;
            end
        end
        if (commit) begin
            if (!same_f && !free_f) begin
                st_d.rr = (st_q.rr == IW'(N - 1)) ? '0 : st_q.rr + IW'(1);
            end
            st_d.vld[tgt]  = 1'b1;
            st_d.key[tgt]  = c_addr;
            st_d.cnt[tgt]  = c_cnt;
            st_d.unc[tgt]  = c_unc;
            st_d.data[tgt] = c_ops;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_killed = inv_valid && (inv_addr[AW-1:ICLB] == lk_addr[AW-1:ICLB]);
    assign lk_hit    = look_f && !lk_killed;
    assign lk_cnt    = st_q.cnt[look_i];
    assign lk_unc    = st_q.unc[look_i];
    assign lk_ops    = st_q.data[look_i];
endmodule

// File: rtl/uopc_stream.sv
module uopc_stream #(
    parameter int AW   = 32,
    parameter int UW   = 16,
    parameter int OPL  = 6,
    parameter int LPE  = 3,
    parameter int WINB = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          lk_req,
    input  logic [AW-1:0]                 lk_addr,
    input  logic                          hit,
    input  logic [$clog2(OPL*LPE+1)-1:0]  cnt,
    input  logic                          unc,
    input  logic [OPL*LPE*UW-1:0]         ops,
    output logic                          rsp_valid,
    output logic                          rsp_hit,
    output logic                          next_valid,
    output logic [AW-1:0]                 next_addr,
    output logic                          line_valid,
    output logic [OPL*UW-1:0]             line_ops,
    output logic [$clog2(OPL+1)-1:0]      line_count,
    output logic                          line_last
);
    localparam int OPS = OPL * LPE;
    localparam int CW  = $clog2(OPS + 1);
    localparam int LW  = $clog2(LPE + 1);
    localparam int LCW = $clog2(OPL + 1);

    typedef struct packed {
        logic              rsp_v;
        logic              rsp_h;
        logic              nv;
        logic [AW-1:0]     na;
        logic              busy;
        logic [LW-1:0]     line;
        logic [LW-1:0]     nlines;
        logic [CW-1:0]     cnt;
        logic [OPS*UW-1:0] snap;
    } strm_st_t;

    strm_st_t st_q, st_d;
    logic     last_now;
    logic     accept;
    int       rem;

    assign last_now = st_q.busy && (st_q.line == st_q.nlines - LW'(1));
    assign accept   = lk_req && (!st_q.busy || last_now);

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = 1'b0;
        st_d.rsp_h = 1'b0;
        st_d.nv    = 1'b0;
        st_d.na    = '0;
        if (st_q.busy) begin
            if (last_now) st_d.busy = 1'b0;
            else          st_d.line = st_q.line + LW'(1);
        end
        if (accept) begin
            st_d.rsp_v = 1'b1;
            st_d.rsp_h = hit;
            if (hit) begin
                st_d.busy   = 1'b1;
                st_d.line   = '0;
                st_d.nlines = LW'((int'(cnt) + OPL - 1) / OPL);
                st_d.cnt    = cnt;
                st_d.snap   = ops;
                st_d.nv     = !unc;
                st_d.na     = {lk_addr[AW-1:WINB] + (AW-WINB)'(1), WINB'(0)};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rem        = int'(st_q.cnt) - int'(st_q.line) * OPL;
        line_count = LCW'((rem > OPL) ? OPL : rem);
    end

    assign rsp_valid  = st_q.rsp_v;
    assign rsp_hit    = st_q.rsp_h;
    assign next_valid = st_q.nv;
    assign next_addr  = st_q.na;
    assign line_valid = st_q.busy;
    assign line_ops   = st_q.snap[int'(st_q.line)*OPL*UW +: OPL*UW];
    assign line_last  = last_now;
endmodule

// File: rtl/uopc_ctrl.sv
module uopc_ctrl
    import uopc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int UOP_W       = 16,
    parameter int TOTAL_LINES = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fill_start,
    input  logic [ADDR_W-1:0]            fill_addr,
    input  logic                         fill_op_valid,
    input  logic [UOP_W-1:0]             fill_op,
    input  logic                         fill_op_branch,
    input  logic                         fill_op_uncond,
    input  logic                         fill_op_end,
    input  logic                         inv_valid,
    input  logic [ADDR_W-1:0]            inv_addr,
    input  logic                         lk_req,
    input  logic [ADDR_W-1:0]            lk_addr,
    output logic                         rsp_valid,
    output logic                         rsp_hit,
    output logic                         next_valid,
    output logic [ADDR_W-1:0]            next_addr,
    output logic                         line_valid,
    output logic [UC_OPS_PER_LINE*UOP_W-1:0] line_ops,
    output logic [2:0]                   line_count,
    output logic                         line_last
);
    localparam int N_ENT = TOTAL_LINES / UC_LINES_PER_ENT;
    localparam int OPS   = UC_OPS_PER_ENT;
    localparam int CW    = $clog2(OPS + 1);

    logic              c_commit, c_unc;
    logic [ADDR_W-1:0] c_addr;
    logic [CW-1:0]     c_cnt;
    logic [OPS*UOP_W-1:0] c_ops;
    logic              s_hit, s_unc;
    logic [CW-1:0]     s_cnt;
    logic [OPS*UOP_W-1:0] s_ops;

    uopc_fill_gate #(
        .AW(ADDR_W), .UW(UOP_W), .OPS(OPS),
        .MAXBR(UC_MAX_BRANCHES), .ICLB(UC_ICL_OFS_BITS)
    ) gate_i (
        .clk(clk), .rst_n(rst_n),
        .start(fill_start), .start_addr(fill_addr),
        .op_valid(fill_op_valid), .op(fill_op),
        .op_br(fill_op_branch), .op_unc(fill_op_uncond), .op_end(fill_op_end),
        .inv_valid(inv_valid), .inv_addr(inv_addr),
        .commit(c_commit), .commit_addr(c_addr), .commit_cnt(c_cnt),
        .commit_unc(c_unc), .commit_ops(c_ops)
    );

    uopc_store #(
        .AW(ADDR_W), .UW(UOP_W), .OPS(OPS), .N(N_ENT), .ICLB(UC_ICL_OFS_BITS)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .commit(c_commit), .c_addr(c_addr), .c_cnt(c_cnt),
        .c_unc(c_unc), .c_ops(c_ops),
        .inv_valid(inv_valid), .inv_addr(inv_addr),
        .lk_addr(lk_addr),
        .lk_hit(s_hit), .lk_cnt(s_cnt), .lk_unc(s_unc), .lk_ops(s_ops)
    );

    uopc_stream #(
        .AW(ADDR_W), .UW(UOP_W), .OPL(UC_OPS_PER_LINE),
        .LPE(UC_LINES_PER_ENT), .WINB(UC_WIN_OFS_BITS)
    ) stream_i (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_addr(lk_addr),
        .hit(s_hit), .cnt(s_cnt), .unc(s_unc), .ops(s_ops),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .next_valid(next_valid), .next_addr(next_addr),
        .line_valid(line_valid), .line_ops(line_ops),
        .line_count(line_count), .line_last(line_last)
    );
endmodule

// File: rtl/uopc_ctrl_chk.sv
module uopc_ctrl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inv_valid,
    input logic [ADDR_W-1:0] inv_addr,
    input logic              lk_req,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              next_valid,
    input logic [ADDR_W-1:0] next_addr,
    input logic              line_valid,
    input logic [2:0]        line_count,
    input logic              line_last
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_req)); // R3
    AST_MISS_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> !line_valid); // R3
    AST_LINE_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> (line_count != 3'd0 && line_count <= 3'd6)); // R3
    AST_LINES_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !line_last) |=> (line_valid && !rsp_valid)); // R11
    AST_FIRST_LINE_WITH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !$past(line_valid && !line_last)) |-> (rsp_valid && rsp_hit)); // R3
    AST_NEXT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        next_valid |-> (rsp_hit && next_addr[4:0] == 5'd0)); // R7
    AST_INV_KILLS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && inv_valid && lk_addr[ADDR_W-1:6] == inv_addr[ADDR_W-1:6]) |=> !rsp_hit); // R12
endmodule

bind uopc_ctrl uopc_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .lk_req(lk_req), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .next_valid(next_valid), .next_addr(next_addr),
    .line_valid(line_valid), .line_count(line_count), .line_last(line_last)
);

// File: tb/uopc_ctrl_tb_top.sv
module uopc_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int UW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fill_start = 0, fill_op_valid = 0, fill_op_branch = 0, fill_op_uncond = 0, fill_op_end = 0;
    logic [AW-1:0] fill_addr = '0, inv_addr = '0, lk_addr = '0;
    logic [UW-1:0] fill_op = '0;
    logic inv_valid = 0, lk_req = 0;
    logic rsp_valid, rsp_hit, next_valid, line_valid, line_last;
    logic [AW-1:0] next_addr;
    logic [6*UW-1:0] line_ops;
    logic [2:0] line_count;

    int n_checks = 0;
    int n_err = 0;

    logic          lr_rsp, lr_hit, lr_nv;
    logic [AW-1:0] lr_na;
    int            lr_lines, lr_cnt;
    logic [UW-1:0] got [18];

    always #(CLK_PERIOD/2) clk = ~clk;

    uopc_ctrl #(.ADDR_W(AW), .UOP_W(UW), .TOTAL_LINES(12)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .fill_start(fill_start), .fill_addr(fill_addr),
        .fill_op_valid(fill_op_valid), .fill_op(fill_op),
        .fill_op_branch(fill_op_branch), .fill_op_uncond(fill_op_uncond),
        .fill_op_end(fill_op_end),
        .inv_valid(inv_valid), .inv_addr(inv_addr),
        .lk_req(lk_req), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .next_valid(next_valid), .next_addr(next_addr),
        .line_valid(line_valid), .line_ops(line_ops),
        .line_count(line_count), .line_last(line_last)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_fill(input logic [AW-1:0] a, input int n, input int nbr, input int unc_at,
                           input logic [UW-1:0] tagv, input int inv_at, input logic [AW-1:0] inv_a);
        @(negedge clk);
        fill_start = 1; fill_addr = a;
        @(negedge clk);
        fill_start = 0;
        for (int i = 0; i < n; i++) begin
            fill_op_valid  = 1;
            fill_op        = tagv + UW'(i);
            fill_op_branch = (i < nbr);
            fill_op_uncond = (i == unc_at);
            fill_op_end    = (i == n - 1);
            inv_valid      = (i == inv_at);
            inv_addr       = inv_a;
            @(negedge clk);
        end
        fill_op_valid = 0; fill_op_branch = 0; fill_op_uncond = 0; fill_op_end = 0; inv_valid = 0;
    endtask

    task automatic invalidate(input logic [AW-1:0] a);
        @(negedge clk);
        inv_valid = 1; inv_addr = a;
        @(negedge clk);
        inv_valid = 0;
    endtask

    task automatic lookup(input logic [AW-1:0] a);
        @(negedge clk);
        lk_req = 1; lk_addr = a;
        @(negedge clk);
        lk_req = 0;
        lr_rsp = rsp_valid; lr_hit = rsp_hit; lr_nv = next_valid; lr_na = next_addr;
        lr_lines = 0; lr_cnt = 0;
        while (line_valid && lr_lines < 4) begin
            for (int k = 0; k < int'(line_count); k++)
                if (lr_cnt + k < 18) got[lr_cnt + k] = line_ops[k*UW +: UW];
            lr_cnt += int'(line_count);
            lr_lines++;
            if (line_last) break;
            @(negedge clk);
        end
    endtask

    task automatic expect_entry(input string req, input logic [AW-1:0] a, input int n,
                                input logic [UW-1:0] tagv, input logic unc);
        int bad;
        lookup(a);
        chk({req, " hit"}, 64'(lr_rsp && lr_hit), 64'(1));
        chk({req, " lines"}, 64'(lr_lines), 64'((n + 5) / 6));
        chk({req, " op count"}, 64'(lr_cnt), 64'(n));
        bad = 0;
        for (int i = 0; i < n && i < 18; i++) if (got[i] !== tagv + UW'(i)) bad++;
        chk({req, " op order mismatches"}, 64'(bad), 64'(0));
        chk({req, " R7 next_valid"}, 64'(lr_nv), 64'(!unc));
        if (!unc) chk({req, " R7 next_addr"}, 64'(lr_na), 64'(((a >> 5) + 1) << 5));
    endtask

    task automatic expect_miss(input string req, input logic [AW-1:0] a);
        lookup(a);
        chk({req, " rsp_valid"}, 64'(lr_rsp), 64'(1));
        chk({req, " miss"}, 64'(lr_hit), 64'(0));
        chk({req, " no line"}, 64'(lr_lines), 64'(0));
    endtask

    task automatic t_reset;
        chk("R1 rsp_valid idle", 64'(rsp_valid), 64'(0));
        chk("R1 line_valid idle", 64'(line_valid), 64'(0));
        expect_miss("R1 empty", 32'h100);
    endtask

    task automatic t_basic;
        do_fill(32'h1004, 14, 0, -1, 16'h0100, -1, '0);
        do_fill(32'h1044, 5, 2, 4, 16'h0200, -1, '0);
        do_fill(32'h1010, 3, 0, -1, 16'h0300, -1, '0);
        do_fill(32'h1028, 2, 1, -1, 16'h0400, -1, '0);
        expect_entry("R3 three lines", 32'h1004, 14, 16'h0100, 0);
        expect_entry("R6 uncond last", 32'h1044, 5, 16'h0200, 1);
        expect_entry("R2 second offset", 32'h1010, 3, 16'h0300, 0);
        expect_miss("R2 window base", 32'h1000);
        invalidate(32'h1033);
        expect_miss("R8 lower window", 32'h1004);
        expect_miss("R8 lower window b", 32'h1010);
        expect_miss("R8 upper window", 32'h1028);
        expect_entry("R8 other line kept", 32'h1044, 5, 16'h0200, 1);
        invalidate(32'h1040);
    endtask

    task automatic t_rules;
        do_fill(32'h2000, 19, 0, -1, 16'h0500, -1, '0);
        expect_miss("R4 19 ops", 32'h2000);
        do_fill(32'h2040, 18, 0, -1, 16'h0600, -1, '0);
        expect_entry("R4 18 ops", 32'h2040, 18, 16'h0600, 0);
        do_fill(32'h2080, 7, 7, -1, 16'h0700, -1, '0);
        expect_miss("R5 7 branches", 32'h2080);
        do_fill(32'h20c0, 7, 6, -1, 16'h0800, -1, '0);
        expect_entry("R5 6 branches", 32'h20c0, 7, 16'h0800, 0);
        do_fill(32'h2100, 4, 0, 1, 16'h0900, -1, '0);
        expect_miss("R6 uncond not last", 32'h2100);
        invalidate(32'h2040);
        invalidate(32'h20c0);
    endtask

    task automatic t_inv_fill;
        do_fill(32'h3000, 8, 0, -1, 16'h0a00, 3, 32'h3020);
        expect_miss("R9 mid fill", 32'h3000);
        do_fill(32'h3040, 4, 0, -1, 16'h0b00, 3, 32'h3040);
        expect_miss("R9 end cycle", 32'h3040);
        do_fill(32'h3080, 4, 0, -1, 16'h0c00, 1, 32'h5000);
        expect_entry("R9 other line", 32'h3080, 4, 16'h0c00, 0);
        invalidate(32'h3080);
    endtask

    task automatic t_inv_lookup;
        do_fill(32'h4000, 2, 0, -1, 16'h0d00, -1, '0);
        @(negedge clk);
        lk_req = 1; lk_addr = 32'h4000; inv_valid = 1; inv_addr = 32'h4010;
        @(negedge clk);
        lk_req = 0; inv_valid = 0;
        chk("R12 rsp_valid", 64'(rsp_valid), 64'(1));
        chk("R12 miss", 64'(rsp_hit), 64'(0));
        expect_miss("R12 gone", 32'h4000);
    endtask

    task automatic t_busy;
        do_fill(32'h4100, 13, 0, -1, 16'h0e00, -1, '0);
        do_fill(32'h4140, 2, 0, -1, 16'h0f00, -1, '0);
        @(negedge clk);
        lk_req = 1; lk_addr = 32'h4100;
        @(negedge clk);
        chk("R3 line0 count", 64'(line_count), 64'(6));
        lk_addr = 32'h4140;
        @(negedge clk);
        lk_req = 0;
        chk("R11 no response", 64'(rsp_valid), 64'(0));
        chk("R11 stream continues", 64'(line_valid), 64'(1));
        chk("R11 line1 first op", 64'(line_ops[UW-1:0]), 64'(16'h0e06));
        @(negedge clk);
        chk("R3 line2 count", 64'(line_count), 64'(1));
        chk("R3 line2 last", 64'(line_last), 64'(1));
        @(negedge clk);
        chk("R3 stream ended", 64'(line_valid), 64'(0));
        expect_entry("R11 other entry", 32'h4140, 2, 16'h0f00, 0);
        invalidate(32'h4100);
        invalidate(32'h4140);
    endtask

    task automatic t_replace;
        do_fill(32'h6000, 2, 0, -1, 16'h1000, -1, '0);
        do_fill(32'h6040, 2, 0, -1, 16'h2000, -1, '0);
        do_fill(32'h6080, 2, 0, -1, 16'h3000, -1, '0);
        do_fill(32'h60c0, 2, 0, -1, 16'h4000, -1, '0);
        do_fill(32'h6100, 2, 0, -1, 16'h5000, -1, '0);
        do_fill(32'h6140, 2, 0, -1, 16'h6000, -1, '0);
        expect_miss("R10 victim 0", 32'h6000);
        expect_miss("R10 victim 1", 32'h6040);
        expect_entry("R10 kept 2", 32'h6080, 2, 16'h3000, 0);
        expect_entry("R10 kept 3", 32'h60c0, 2, 16'h4000, 0);
        do_fill(32'h6080, 3, 0, -1, 16'h7700, -1, '0);
        expect_entry("R10 same key rewritten", 32'h6080, 3, 16'h7700, 0);
        expect_entry("R10 same key no evict", 32'h60c0, 2, 16'h4000, 0);
        invalidate(32'h60c0);
        do_fill(32'h6180, 2, 0, -1, 16'h8000, -1, '0);
        expect_entry("R10 free slot used", 32'h6080, 3, 16'h7700, 0);
        expect_entry("R10 free keeps 4", 32'h6100, 2, 16'h5000, 0);
        do_fill(32'h61c0, 2, 0, -1, 16'h9000, -1, '0);
        expect_miss("R10 victim 2", 32'h6080);
        expect_entry("R10 kept 5", 32'h6140, 2, 16'h6000, 0);
        expect_entry("R10 kept 6", 32'h6180, 2, 16'h8000, 0);
        expect_entry("R10 new 7", 32'h61c0, 2, 16'h9000, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_basic;
        t_rules;
        t_inv_fill;
        t_inv_lookup;
        t_busy;
        t_replace;
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule